// File: doc/BRIEF.md
# Reset Sequencer with Cause Discrimination

This block is the reset controller of a small microcontroller. It merges three reset sources into one active-high internal reset. The first is a power-on event, given as the asynchronous release of `rst_ni`. The second is an active-low reset pad shared with the outside world. The block reads the pad as a level and can pull it low through a drive enable. The third is a pair of one-cycle requests from a watchdog and from a clock monitor.

After power-up the internal reset stays high for a fixed oscillator-settling delay, and longer if the pad is still held low. An internal request pulls the pad low for a short burst and starts a reset sequence. A fixed number of cycles into that sequence the block samples the pad. If the pad is still low, someone outside is holding it, and the cause is logged as external. If the pad is high, the reset came from inside. A flag register keeps every cause seen, until a clear strobe or the next power-on.

Top module: `rstgen_top`

## Requirements
- R1: With the pad high, after `rst_ni` releases, `rst_o` stays high for exactly `STAB_CYC + HOLD_CYC` rising edges (4064 + 8 = 4072 by default) and then falls, right after a clock edge.
- R2: If the pad is still low when the settling delay ends, `rst_o` stays high. Once the pad is released, `rst_o` falls on the 11th edge after release: 2 synchroniser edges, 1 decision edge and 8 hold edges.
- R3: Only `rst_ni` starts the settling delay. Pad and internal resets that come after power-up never take the settling delay.
- R4: A watchdog or clock-monitor request seen at a clock edge while the block is idle starts a sequence. From the next cycle, `pin_drive_o` is high for exactly 4 cycles, and `rst_o` stays high for 16 edges (6 cycles to the sample, 1 sample edge, 1 transfer edge, 8 hold edges).
- R5: The pad passes through a 2-flop synchroniser. A pad pulled low for L cycles from idle raises `rst_o` after the 3rd edge. The cause is flagged external exactly when L >= 8. `rst_o` then stays high for 18 edges when L < 8, or for L + 11 edges when L >= 8.
- R6: A sequence started only by the pad never drives the pad.
- R7: `cause_o` holds flags: bit 0 power-on, bit 1 external, bit 2 watchdog, bit 3 clock monitor. A request sets its flag on the next edge in any state, and a set wins over a clear in the same cycle.
- R8: A `cause_clr_i` pulse with no request present clears every flag on the next edge.
- R9: Power-on reset sets `cause_o` to 4'b0001 at once and clears all other flags.
- R10: A request that arrives while a sequence is running sets its flag but does not lengthen the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pin_i | input | 1 | Level read from the shared reset pad (low = reset) |
| wdog_req_i | input | 1 | Watchdog timeout request |
| cmon_req_i | input | 1 | Clock-monitor failure request |
| cause_clr_i | input | 1 | Clear strobe for the cause flags |
| rst_o | output | 1 | Internal reset, active high |
| pin_drive_o | output | 1 | Pull the reset pad low when high |
| cause_o | output | 4 | Reset cause flags |

## Verification
Every result is measured in rising edges counted from the negedge where the stimulus is applied. The pad is modelled as a wired-AND of the bench's external pull and `pin_drive_o`. The bench samples `rst_o`, `pin_drive_o` and `cause_o` at each following negedge and stops counting at the first sample with `rst_o` low. The expected edge counts are worked out from the synchroniser depth, sample point and hold length: 4072, 11, 16, and 18 or L + 11. A sweep of external pulse lengths from 1 to 12 cycles covers both sides of the 8-cycle threshold. Cause flags are read one negedge after the edge that should change them.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [2:0] {
    ST_STAB,
    ST_WAITPIN,
    ST_IDLE,
    ST_SEQ,
    ST_HOLD
  } rst_state_e;

  localparam int CAUSE_W = 4;
  localparam int CA_POR  = 0;
  localparam int CA_EXT  = 1;
  localparam int CA_WDOG = 2;
  localparam int CA_CMON = 3;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= RST_VAL;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
  import rstgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;
  localparam logic [CAUSE_W-1:0] POR_VAL = CAUSE_W'(1) << CA_POR;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cause_q <= POR_VAL;
    else         cause_q <= (clr_i ? '0 : cause_q) | set_i;

  assign cause_o = cause_q;

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> cause_o == '0);

  assert_set_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((cause_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int STAB_CYC    = 4064,
  parameter int SYNC_STAGES = 2,
  parameter int DRIVE_CYC   = 4,
  parameter int SAMPLE_CYC  = 6,
  parameter int HOLD_CYC    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  logic               wdog_req_i,
  input  logic               cmon_req_i,
  input  logic               cause_clr_i,
  output logic               rst_o,
  output logic               pin_drive_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int MAX_A   = (STAB_CYC > HOLD_CYC) ? STAB_CYC : HOLD_CYC;
  localparam int MAX_B   = (SAMPLE_CYC > DRIVE_CYC) ? SAMPLE_CYC : DRIVE_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DRV_W   = $clog2(DRIVE_CYC + 2);

  rst_state_e         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               drv_q, drv_d;
  logic               ext_set;
  logic               pin_s, pin_low, int_req;
  logic [CAUSE_W-1:0] cause_set;

  rstgen_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign pin_low = ~pin_s;
  assign int_req = wdog_req_i | cmon_req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    drv_d   = drv_q;
    ext_set = 1'b0;
    unique case (state_q)
      ST_STAB: begin
        if (cnt_q == CNT_W'(STAB_CYC - 1)) begin
          cnt_d   = '0;
          state_d = pin_low ? ST_WAITPIN : ST_HOLD;
        end
      end
      ST_WAITPIN: begin
        cnt_d = '0;
        if (!pin_low) state_d = ST_HOLD;
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (int_req || pin_low) begin
          state_d = ST_SEQ;
          drv_d   = int_req;
        end
      end
      ST_SEQ: begin
        if (cnt_q == CNT_W'(SAMPLE_CYC)) begin
          cnt_d = '0;
          drv_d = 1'b0;
          if (pin_low) begin
            ext_set = 1'b1;
            state_d = ST_WAITPIN;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        cnt_d   = '0;
        state_d = ST_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_STAB;
      cnt_q   <= '0;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      drv_q   <= drv_d;
    end

  assign rst_o       = (state_q != ST_IDLE);
  assign pin_drive_o = (state_q == ST_SEQ) && drv_q && (cnt_q < CNT_W'(DRIVE_CYC));

  always_comb begin
    cause_set          = '0;
    cause_set[CA_EXT]  = ext_set;
    cause_set[CA_WDOG] = wdog_req_i;
    cause_set[CA_CMON] = cmon_req_i;
  end

  rstgen_cause u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cause_set),
    .clr_i  (cause_clr_i),
    .cause_o(cause_o)
  );

  // checker state
  logic [CNT_W-1:0] por_age_q;
  logic [DRV_W-1:0] drv_run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      por_age_q <= '0;
      drv_run_q <= '0;
    end else begin
      if (por_age_q != CNT_W'(STAB_CYC)) por_age_q <= por_age_q + 1'b1;
      if (!pin_drive_o)                        drv_run_q <= '0;
      else if (drv_run_q != DRV_W'(DRIVE_CYC + 1)) drv_run_q <= drv_run_q + 1'b1;
    end

  assert_por_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_o |-> por_age_q == CNT_W'(STAB_CYC));

  assert_drive_in_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> rst_o);

  assert_drive_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_run_q <= DRV_W'(DRIVE_CYC));

  assert_pad_only_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pin_low && !int_req) |=> !pin_drive_o);
endmodule

// File: tb/sim_rstgen_top.sv
module sim_rstgen_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB  = 4064;
  localparam int HOLD  = 8;
  localparam int SYNC  = 2;
  localparam int SAMPLE = 6;
  localparam int DRIVE = 4;
  localparam int EXT_MIN = SAMPLE + SYNC;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wdog_req_i = 1'b0;
  logic cmon_req_i = 1'b0;
  logic cause_clr_i = 1'b0;
  logic ext_low = 1'b0;
  logic pin_i;
  logic rst_o, pin_drive_o;
  logic [3:0] cause_o;
  int n_tot = 0;
  int n_bad = 0;
  bit done = 1'b0;

  assign pin_i = ~(pin_drive_o | ext_low);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rstgen_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
    .wdog_req_i(wdog_req_i), .cmon_req_i(cmon_req_i), .cause_clr_i(cause_clr_i),
    .rst_o(rst_o), .pin_drive_o(pin_drive_o), .cause_o(cause_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk_i); cause_clr_i = 1'b1;
    @(negedge clk_i); cause_clr_i = 1'b0;
    check(cause_o == 4'b0000, "R8", cause_o, 0);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic run_int(input bit w, input bit c, input int extra_at,
                         output int n, output int drv);
    @(negedge clk_i);
    wdog_req_i = w; cmon_req_i = c;
    n = 0; drv = 0;
    do begin
      @(negedge clk_i);
      n++;
      wdog_req_i = 1'b0;
      cmon_req_i = (n == extra_at);
      if (pin_drive_o) drv++;
    end while (rst_o && n < 1000);
    cmon_req_i = 1'b0;
  endtask

  task automatic run_ext(input int len, output int n, output int drv, output int first_rst);
    @(negedge clk_i);
    ext_low = 1'b1;
    n = 0; drv = 0; first_rst = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == len) ext_low = 1'b0;
      if (pin_drive_o) drv++;
      if (rst_o && first_rst == 0) first_rst = n;
    end while ((rst_o || n < SYNC + 2) && n < 1000);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    int n, drv, fr;
    // reset state
    idle(2);
    check(rst_o == 1'b1, "R9 rst", rst_o, 1);
    check(pin_drive_o == 1'b0, "R9 drive", pin_drive_o, 0);
    check(cause_o == 4'b0001, "R9 cause", cause_o, 1);

    // R1: power-on delay with pad high
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (rst_o && n < 10000);
    check(n == STAB + HOLD, "R1 por length", n, STAB + HOLD);
    check(cause_o == 4'b0001, "R1 cause", cause_o, 1);
    clear_flags();

    // R4/R7: watchdog, clock monitor, both
    run_int(1'b1, 1'b0, 0, n, drv);
    check(n == SAMPLE + 2 + HOLD, "R4 wdog length", n, SAMPLE + 2 + HOLD);
    check(drv == DRIVE, "R4 drive cycles", drv, DRIVE);
    check(cause_o == 4'b0100, "R7 wdog flag", cause_o, 4);
    clear_flags();
    run_int(1'b0, 1'b1, 0, n, drv);
    check(n == SAMPLE + 2 + HOLD, "R4 cmon length", n, SAMPLE + 2 + HOLD);
    check(drv == DRIVE, "R4 cmon drive", drv, DRIVE);
    check(cause_o == 4'b1000, "R7 cmon flag", cause_o, 8);
    clear_flags();
    run_int(1'b1, 1'b1, 0, n, drv);
    check(cause_o == 4'b1100, "R7 both flags", cause_o, 12);
    clear_flags();

    // R10: request during a running sequence
    run_int(1'b1, 1'b0, 10, n, drv);
    check(n == SAMPLE + 2 + HOLD, "R10 no restart", n, SAMPLE + 2 + HOLD);
    check(cause_o == 4'b1100, "R10 late flag", cause_o, 12);
    clear_flags();

    // R5/R6/R3: pad pulse sweep
    for (int len = 1; len <= 12; len++) begin
      int exp_n;
      exp_n = (len < EXT_MIN) ? (SYNC + 1 + SAMPLE + 1 + HOLD) : (len + SYNC + 1 + HOLD);
      idle(3);
      run_ext(len, n, drv, fr);
      check(n == exp_n, "R5 pulse length", n, exp_n);
      check(fr == SYNC + 1, "R5 sync latency", fr, SYNC + 1);
      check(cause_o[1] == (len >= EXT_MIN), "R5 ext flag", cause_o[1], len >= EXT_MIN);
      check(drv == 0, "R6 no drive", drv, 0);
      check(n < STAB, "R3 no settle delay", n, exp_n);
      clear_flags();
    end

    // R7: set beats clear
    @(negedge clk_i); cause_clr_i = 1'b1; wdog_req_i = 1'b1;
    @(negedge clk_i); cause_clr_i = 1'b0; wdog_req_i = 1'b0;
    check(cause_o == 4'b0100, "R7 set over clear", cause_o, 4);
    n = 0;
    do begin @(negedge clk_i); n++; end while (rst_o && n < 1000);

    // R2/R9: power-on with pad held low, stale flags present
    ext_low = 1'b1;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check(cause_o == 4'b0001, "R9 por clears", cause_o, 1);
    rst_ni = 1'b1;
    idle(STAB + 900);
    check(rst_o == 1'b1, "R2 held by pad", rst_o, 1);
    ext_low = 1'b0;
    n = 0;
    do begin @(negedge clk_i); n++; end while (rst_o && n < 1000);
    check(n == SYNC + 1 + HOLD, "R2 release length", n, SYNC + 1 + HOLD);
    check(cause_o == 4'b0001, "R2 cause", cause_o, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule